// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Register Bank

This block is the host-side register file of a four-channel digital-to-analog converter. Each channel has a staging pair: a 16-bit code word and a 3-bit output range code. Each channel also has an active pair that the converter core uses. The active values leave the block on plain output ports. The host moves values into the staging pair with an active-low write strobe, and copies them to the active pair with an update strobe. Because of this double buffering, all four channels can be loaded one at a time and then switched together.

The host reaches the block over a bidirectional 16-bit code bus and a bidirectional 3-bit range bus. A 3-bit channel select chooses one channel. Two extra select values reach every channel at once. A read control turns the buses around so the block drives them. During a read, the update line stops moving data and instead chooses which register is returned: the staging pair or the active pair. A build-time option models boards that wire the range pins to fixed levels. In that option, range codes are never stored and the range bus is never driven. Strobes are brought into the system clock through synchroniser flops and acted on at their rising edge.

Top module: `dacbank_top`

## Requirements
- R1: After synchronous reset, every staging and active code word is zero and every range code is 3'b000.
- R2: A rising edge of the write strobe `wr_n` while `rd` is low loads the code bus and the range bus into the staging pair of the selected channel. The active pairs are left unchanged.
- R3: While `rd` is high, a write strobe pulse changes no staging register.
- R4: A rising edge of `upd` while `rd` is low copies the staging code word and the staging range code of the selected channel into its active pair. Other channels keep their active values.
- R5: While `rd` is high and `upd` is low, the code bus and the range bus carry the staging pair of the selected channel.
- R6: While `rd` is high and `upd` is high, the buses carry the active pair of the selected channel.
- R7: While `rd` is low the block does not drive either bus, so the host's values on the buses are the ones written.
- R8: Select values 0 to 3 pick one channel. Values 4 and 5 pick all four channels for writes and updates. Values 6 and 7 pick no channel for writes or updates.
- R9: A read with a select value of 4 or above returns channel 0.
- R10: A rising edge of `upd` while `rd` is high leaves all active registers unchanged.
- R11: With `FIXED_SPAN` set, every range register stays 3'b000 and the range bus is never driven, including during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe; acts on its rising edge |
| upd | input | 1 | Update strobe when `rd` is low; readback select when `rd` is high |
| rd | input | 1 | Read control; high turns both buses into outputs |
| chan_sel | input | 3 | Channel select (0-3 single, 4-5 all, 6-7 none) |
| code_io | inout | 16 | Bidirectional code word bus |
| range_io | inout | 3 | Bidirectional range code bus |
| act_code | output | 64 | Active code words, channel n in bits [16n+15:16n] |
| act_range | output | 12 | Active range codes, channel n in bits [3n+2:3n] |

## Verification
The assertions assume that `rd` is a synchronous level that does not change while a synchronised strobe edge is in flight. They also assume that `chan_sel` and both buses stay stable from the moment a strobe starts until its edge has been consumed. The stimulus holds each strobe active for four cycles, keeps the select and the bus values for five cycles after release, and toggles `rd` only when no strobe edge is pending. During a read, the host side of both buses is released, so only the block drives them.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam int RW  = 3;
    localparam int SELW = 3;
    localparam int IDXW = $clog2(NCH);
    localparam logic [RW-1:0] RANGE_RST = '0;

    typedef struct packed {
        logic [CW-1:0] code;
        logic [RW-1:0] rng;
    } chan_word_t;

    // select value -> set of channels touched by write/update
    function automatic logic [NCH-1:0] sel_hits(input logic [SELW-1:0] s);
        logic [NCH-1:0] h;
        h = '0;
        if (int'(s) < NCH)
            h[s[IDXW-1:0]] = 1'b1;
        else if (int'(s) == NCH || int'(s) == NCH + 1)
            h = '1;
        return h;
    endfunction

    // select value -> channel returned on readback
    function automatic logic [IDXW-1:0] sel_read_idx(input logic [SELW-1:0] s);
        return (int'(s) < NCH) ? s[IDXW-1:0] : '0;
    endfunction
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int   STAGES  = 2,
    parameter logic IDLE_LV = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {(STAGES+1){IDLE_LV}};
        else     chain <= {chain[STAGES-1:0], din};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // R2 R4: an edge event lasts exactly one cycle
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/chan_regs.sv
module chan_regs
    import dacbank_pkg::*;
#(
    parameter bit FIXED_SPAN = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ld_stage,
    input  logic       ld_act,
    input  chan_word_t wr_word,
    output chan_word_t stage_q,
    output chan_word_t act_q
);
    chan_word_t stage_r, act_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_r <= '{code: '0, rng: RANGE_RST};
            act_r   <= '{code: '0, rng: RANGE_RST};
        end else begin
            if (ld_stage) stage_r <= wr_word;
            if (ld_act)   act_r   <= stage_r;
        end
    end

    generate
        if (FIXED_SPAN) begin : g_fixed
            assign stage_q = '{code: stage_r.code, rng: RANGE_RST};
            assign act_q   = '{code: act_r.code,   rng: RANGE_RST};
        end else begin : g_prog
            assign stage_q = stage_r;
            assign act_q   = act_r;
        end
    endgenerate

    // R4: the active pair takes the staging pair seen at the load cycle
    act_copy_chk: assert property (@(posedge clk) disable iff (rst)
        ld_act |=> act_q == $past(stage_q));

    // R4: without a load the active pair holds
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_act |=> $stable(act_q));
endmodule

// File: rtl/readback_mux.sv
module readback_mux
    import dacbank_pkg::*;
(
    input  chan_word_t [NCH-1:0] stage_all,
    input  chan_word_t [NCH-1:0] act_all,
    input  logic [SELW-1:0]      sel,
    input  logic                 pick_act,
    output chan_word_t           rb_word
);
    logic [IDXW-1:0] idx;

    always_comb begin
        idx     = sel_read_idx(sel);
        rb_word = pick_act ? act_all[idx] : stage_all[idx];
    end
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
    import dacbank_pkg::*;
#(
    parameter bit FIXED_SPAN  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_n,
    input  logic                upd,
    input  logic                rd,
    input  logic [SELW-1:0]     chan_sel,
    inout  wire  [CW-1:0]       code_io,
    inout  wire  [RW-1:0]       range_io,
    output logic [NCH*CW-1:0]   act_code,
    output logic [NCH*RW-1:0]   act_range
);
    logic wr_evt, upd_evt;
    logic [NCH-1:0] hits, ld_stage, ld_act;
    chan_word_t wr_word, rb_word;
    chan_word_t [NCH-1:0] stage_all, act_all;

    strobe_edge #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_wr_edge (
        .clk(clk), .rst(rst), .din(wr_n), .rise(wr_evt));

    strobe_edge #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b0)) u_upd_edge (
        .clk(clk), .rst(rst), .din(upd), .rise(upd_evt));

    always_comb begin
        hits     = sel_hits(chan_sel);
        ld_stage = (wr_evt  && !rd) ? hits : '0;
        ld_act   = (upd_evt && !rd) ? hits : '0;
        wr_word  = '{code: code_io, rng: range_io};
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            chan_regs #(.FIXED_SPAN(FIXED_SPAN)) u_ch (
                .clk(clk), .rst(rst),
                .ld_stage(ld_stage[c]), .ld_act(ld_act[c]),
                .wr_word(wr_word),
                .stage_q(stage_all[c]), .act_q(act_all[c]));
            assign act_code[c*CW +: CW]  = act_all[c].code;
            assign act_range[c*RW +: RW] = act_all[c].rng;
        end
    endgenerate

    readback_mux u_rb (
        .stage_all(stage_all), .act_all(act_all),
        .sel(chan_sel), .pick_act(upd), .rb_word(rb_word));

    assign code_io = rd ? rb_word.code : 'z;

    generate
        if (FIXED_SPAN) begin : g_rng_off
            assign range_io = 'z;
        end else begin : g_rng_on
            assign range_io = rd ? rb_word.rng : 'z;
        end
    endgenerate

    // R3: a read cycle never alters staging registers
    rd_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        rd |=> $stable(stage_all));

    // R10: a read cycle never alters active registers
    rd_blocks_update_chk: assert property (@(posedge clk) disable iff (rst)
        rd |=> $stable(act_all));

    // R1: the cycle after reset all active outputs are zero
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (act_code == '0 && act_range == '0));

    // R8: a write or update never touches more than one channel unless broadcast
    sel_scope_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(chan_sel) < NCH) |-> $onehot0(ld_stage | ld_act));
endmodule

// File: tb/dacbank_top_test.sv
module dacbank_top_test;
    localparam int PER = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_n = 1'b1, upd = 1'b0, rd = 1'b0;
    logic [2:0] chan_sel = '0;
    logic tb_oe = 1'b1;
    logic [15:0] tb_d = '0;
    logic [2:0]  tb_s = '0;
    wire  [15:0] dq, dq2;
    wire  [2:0]  sq, sq2;
    logic [63:0] act_code, act_code2;
    logic [11:0] act_range, act_range2;

    int total = 0, bad = 0;
    bit done = 0;

    logic [15:0] m_sd [4];
    logic [2:0]  m_ss [4];
    logic [15:0] m_ad [4];
    logic [2:0]  m_as [4];

    assign dq  = tb_oe ? tb_d : 'z;
    assign sq  = tb_oe ? tb_s : 'z;
    assign dq2 = tb_oe ? tb_d : 'z;
    assign sq2 = tb_oe ? tb_s : 3'b101;

    always #(PER/2) clk = ~clk;

    dacbank_top uut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .upd(upd), .rd(rd), .chan_sel(chan_sel),
        .code_io(dq), .range_io(sq), .act_code(act_code), .act_range(act_range));

    dacbank_top #(.FIXED_SPAN(1'b1)) uut_fix (
        .clk(clk), .rst(rst), .wr_n(wr_n), .upd(upd), .rd(rd), .chan_sel(chan_sel),
        .code_io(dq2), .range_io(sq2), .act_code(act_code2), .act_range(act_range2));

    function automatic bit hit(input logic [2:0] a, input int c);
        if (a < 3'd4) return int'(a) == c;
        return (a == 3'd4 || a == 3'd5);
    endfunction

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expv);
        total++;
        if (actual !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, actual, expv);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_act(input string req);
        for (int c = 0; c < 4; c++) begin
            chk(req, {16'h0, act_code[c*16 +: 16]}, {16'h0, m_ad[c]});
            chk(req, {29'h0, act_range[c*3 +: 3]}, {29'h0, m_as[c]});
        end
    endtask

    // write strobe with rd held low (R2, R7)
    task automatic do_write(input logic [2:0] a, input logic [15:0] d, input logic [2:0] s);
        chan_sel = a; tb_d = d; tb_s = s; tb_oe = 1'b1;
        wr_n = 1'b0; wait_n(4);
        wr_n = 1'b1; wait_n(5);
        for (int c = 0; c < 4; c++)
            if (hit(a, c)) begin m_sd[c] = d; m_ss[c] = s; end
    endtask

    task automatic do_update(input logic [2:0] a);
        chan_sel = a;
        upd = 1'b1; wait_n(4);
        upd = 1'b0; wait_n(5);
        for (int c = 0; c < 4; c++)
            if (hit(a, c)) begin m_ad[c] = m_sd[c]; m_as[c] = m_ss[c]; end
    endtask

    task automatic read_chk(input logic [2:0] a, input logic sel, input string req);
        int idx;
        idx = (a < 3'd4) ? int'(a) : 0;
        chan_sel = a; tb_oe = 1'b0; rd = 1'b1; upd = sel;
        wait_n(3);
        chk(req, {16'h0, dq}, {16'h0, sel ? m_ad[idx] : m_sd[idx]});
        chk(req, {29'h0, sq}, {29'h0, sel ? m_as[idx] : m_ss[idx]});
        upd = 1'b0; wait_n(4);
        rd = 1'b0; tb_oe = 1'b1; wait_n(1);
    endtask

    initial begin
        #(PER*150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_sd[c] = '0; m_ss[c] = '0; m_ad[c] = '0; m_as[c] = '0;
        end
        wait_n(4);
        rst = 1'b0;
        wait_n(2);

        // R1 reset state, staging via readback (R5)
        check_act("R1");
        for (int c = 0; c < 4; c++) read_chk(3'(c), 1'b0, "R1");

        // R2 R7 individual writes, active unchanged
        for (int c = 0; c < 4; c++)
            do_write(3'(c), 16'h1111 * 16'(c + 1) ^ 16'h8000, 3'(c + 1));
        check_act("R2");
        for (int c = 0; c < 4; c++) read_chk(3'(c), 1'b0, "R5");

        // R4 selective update, R6 readback of active
        do_update(3'd1);
        do_update(3'd3);
        check_act("R4");
        for (int c = 0; c < 4; c++) read_chk(3'(c), 1'b1, "R6");

        // R9 out-of-range readback returns channel 0
        read_chk(3'd6, 1'b0, "R9");
        read_chk(3'd4, 1'b1, "R9");
        read_chk(3'd7, 1'b1, "R9");

        // R3 write strobe during a read (upd high -> bus shows active value)
        chan_sel = 3'd2; tb_oe = 1'b0; rd = 1'b1; upd = 1'b1;
        wait_n(2);
        wr_n = 1'b0; wait_n(4); wr_n = 1'b1; wait_n(5);
        upd = 1'b0; wait_n(5);
        rd = 1'b0; tb_oe = 1'b1; wait_n(1);
        read_chk(3'd2, 1'b0, "R3");

        // R10 update edge during a read moves nothing
        chan_sel = 3'd0; tb_oe = 1'b0; rd = 1'b1;
        wait_n(1);
        upd = 1'b1; wait_n(4); upd = 1'b0; wait_n(5);
        rd = 1'b0; tb_oe = 1'b1; wait_n(1);
        check_act("R10");

        // R8 broadcast write, null write, broadcast update
        do_write(3'd4, 16'hABCD, 3'd5);
        for (int c = 0; c < 4; c++) read_chk(3'(c), 1'b0, "R8");
        do_write(3'd6, 16'h0F0F, 3'd2);
        do_write(3'd7, 16'hF0F0, 3'd3);
        for (int c = 0; c < 4; c++) read_chk(3'(c), 1'b0, "R8");
        do_write(3'd2, 16'h5A5A, 3'd6);
        do_update(3'd6);
        check_act("R8");
        do_update(3'd5);
        check_act("R8");

        // sweep every range code over every channel
        for (int k = 0; k < 8; k++) begin
            do_write(3'(k % 4), 16'(k * 16'h2345 + 7), 3'(k));
            do_update(3'(k % 4));
            read_chk(3'(k % 4), 1'b0, "R5");
            read_chk(3'(k % 4), 1'b1, "R6");
        end
        check_act("R4");

        // R11 fixed-range build: codes follow, ranges stay zero, bus undriven
        for (int c = 0; c < 4; c++) begin
            chk("R11", {16'h0, act_code2[c*16 +: 16]}, {16'h0, m_ad[c]});
            chk("R11", {29'h0, act_range2[c*3 +: 3]}, 32'h0);
        end
        chan_sel = 3'd1; tb_oe = 1'b0; rd = 1'b1; upd = 1'b1;
        wait_n(3);
        chk("R11", {29'h0, sq2}, 32'h5);
        chk("R11", {16'h0, dq2}, {16'h0, m_ad[1]});
        upd = 1'b0; wait_n(4);
        rd = 1'b0; tb_oe = 1'b1; wait_n(1);

        // R1 reset again clears everything
        rst = 1'b1; wait_n(2); rst = 1'b0; wait_n(1);
        for (int c = 0; c < 4; c++) begin
            m_sd[c] = '0; m_ss[c] = '0; m_ad[c] = '0; m_as[c] = '0;
        end
        check_act("R1");
        read_chk(3'd3, 1'b0, "R1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule